// File: doc/BRIEF.md
# Page Write Programming Sequencer

This block sits behind the serial command decoder of a small byte-addressed non-volatile memory. Once the decoder has recognised a write command and its start address, the sequencer collects the data bytes that follow into an eight-slot page buffer. The slot pointer is the low three address bits, which step by one per byte and wrap inside the page. The upper address bits are held for the whole command.

When chip select rises exactly on a byte boundary, with the write-enable latch set and the write-protect pin high, the sequencer commits. It then runs a self-timed programming cycle. Every slot that received a byte is written once into an external synchronous byte RAM, which stands in for the cell array. Before each slot is written, its address is offered to an outside protection check, and any address that check flags is skipped. The cycle length is a parameter counted in system clocks. When the cycle ends, `busy` falls and a one-cycle pulse asks the command logic to clear its write-enable latch.

A chip-select rise in the middle of a byte throws the page away. So does the write-protect pin going low while the command is open.

Top module: `page_prog_seq`

## Requirements
- R1: After synchronous reset, `busy`, `ram_we` and `clr_wel` are all 0.
- R2: The byte number i (counting from 0) of a command is buffered in slot (start_addr[2:0] + i) mod 8. Its RAM address is {start_addr[8:3], slot}, so the upper six address bits never change inside one command.
- R3: If more than 8 bytes are sent, the pointer wraps and a later byte replaces the earlier byte in the same slot. Each slot is written at most once per cycle, and it carries the last byte sent to it.
- R4: A cycle starts only on `cs_rise_full`. A `cs_rise_partial` while bytes are being collected discards the page: no RAM write and no `busy`.
- R5: If `wel` is 0 or `wp_n` is 0 in the cycle that `cs_rise_full` arrives, the page is discarded and the block returns to idle.
- R6: Any cycle with `wp_n` = 0 while a command is open cancels it, even if `wp_n` returns high before chip select rises.
- R7: Once a cycle has started, `wp_n` has no effect on it.
- R8: During a cycle, slots are visited in ascending order, one per clock. A slot whose address `chk_addr` gets `prot_hit` = 1 in the cycle it is shown is not written.
- R9: Slots that received no byte in the command are never written.
- R10: `busy` rises on the clock after the committing edge and stays high for exactly CYCLE_CLKS clocks (CYCLE_CLKS >= 9). `clr_wel` is a single-cycle pulse in the first clock in which `busy` is low again.
- R11: `wr_start`, `byte_valid` and chip-select events that arrive while `busy` is high are ignored: they cause no extra writes and no second cycle.
- R12: A `cs_rise_full` that arrives before any data byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | Pulse: write opcode and address decoded |
| start_addr | input | ADDR_W | Start byte address, valid with `wr_start` |
| byte_valid | input | 1 | Pulse: one complete data byte received |
| byte_data | input | DATA_W | Data byte, valid with `byte_valid` |
| cs_rise_full | input | 1 | Pulse: chip select rose right after a complete byte |
| cs_rise_partial | input | 1 | Pulse: chip select rose in the middle of a byte |
| wel | input | 1 | Write-enable latch state |
| wp_n | input | 1 | Write-protect pin, active low |
| chk_addr | output | ADDR_W | Address offered to the protection check |
| prot_hit | input | 1 | Protection check result for `chk_addr`, same cycle |
| busy | output | 1 | Programming cycle in progress |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| clr_wel | output | 1 | One-cycle request to clear the write-enable latch |

## Verification
The bench sweeps every in-page start offset against byte counts from one to ten. This exercises the pointer wrap. A design that carried into the upper address bits would write to the next page, and one that appended instead of overwriting would issue more than eight writes. Separate runs check each abort path: a mid-byte chip-select rise, a clear latch, a protect pin low at the rise, and a one-cycle protect glitch during collection. A design that latched `wp_n` only at the rise would still commit after that glitch. Further runs check a protect pin held low during the cycle, a protection boundary that falls inside a page, a command injected while busy, and a commit with no data. Against the last of these, a design that ignored the valid mask would program stale slots.

// File: rtl/page_prog_pkg.sv
package page_prog_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_COLLECT = 2'd1,
    ST_PROG    = 2'd2
  } seq_state_t;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int PAGE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  logic [DATA_W-1:0]     slot_data [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] slot_vld;

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        slot_vld[g] <= 1'b0;
      end else if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_vld[g] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (wr_en && wr_idx == IDX_W'(g)) begin
        slot_data[g] <= wr_data;
      end
    end
  end

  assign rd_data   = slot_data[rd_idx];
  assign rd_valid  = slot_vld[rd_idx];
  assign any_valid = |slot_vld;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int CYCLE_CLKS = 20,
  localparam int CW        = $clog2(CYCLE_CLKS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic stop,
  output logic done
);
  logic [CW-1:0] cnt;
  logic          active;

  assign done = active && (cnt == CW'(CYCLE_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (stop) begin
      active <= 1'b0;
    end else if (active && !done) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/page_prog_seq.sv
module page_prog_seq
  import page_prog_pkg::*;
#(
  parameter int ADDR_W     = 9,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int CYCLE_CLKS = 20,
  localparam int IDX_W     = $clog2(PAGE_BYTES),
  localparam int BASE_W    = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_valid,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              cs_rise_full,
  input  logic              cs_rise_partial,
  input  logic              wel,
  input  logic              wp_n,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              prot_hit,
  output logic              busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              clr_wel
);
  localparam logic [IDX_W:0] SCAN_END = (IDX_W + 1)'(PAGE_BYTES);

  seq_state_t        state;
  logic [BASE_W-1:0] base_q;
  logic [IDX_W-1:0]  ptr_q;
  logic [IDX_W:0]    slot_q;

  logic              buf_clr, buf_wr, any_valid, rd_valid;
  logic [DATA_W-1:0] rd_data;
  logic              tmr_start, tmr_done, finish, scan_done;
  logic              abort_c, commit_c;

  assign scan_done = (slot_q == SCAN_END);
  assign chk_addr  = {base_q, slot_q[IDX_W-1:0]};
  assign abort_c   = cs_rise_partial || !wp_n;
  assign commit_c  = cs_rise_full && wel && any_valid;
  assign buf_clr   = (state == ST_IDLE) && wr_start;
  assign buf_wr    = (state == ST_COLLECT) && byte_valid && !abort_c && !cs_rise_full;
  assign tmr_start = (state == ST_COLLECT) && !abort_c && commit_c;
  assign finish    = (state == ST_PROG) && scan_done && tmr_done;

  page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .clr(buf_clr), .wr_en(buf_wr), .wr_idx(ptr_q),
    .wr_data(byte_data), .rd_idx(slot_q[IDX_W-1:0]), .rd_data(rd_data),
    .rd_valid(rd_valid), .any_valid(any_valid)
  );

  prog_timer #(.CYCLE_CLKS(CYCLE_CLKS)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .stop(finish), .done(tmr_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      base_q    <= '0;
      ptr_q     <= '0;
      slot_q    <= '0;
      busy      <= 1'b0;
      clr_wel   <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      clr_wel <= 1'b0;
      ram_we  <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_start) begin
            base_q <= start_addr[ADDR_W-1:IDX_W];
            ptr_q  <= start_addr[IDX_W-1:0];
            state  <= ST_COLLECT;
          end
        end
        ST_COLLECT: begin
          if (abort_c) begin
            state <= ST_IDLE;
          end else if (cs_rise_full) begin
            if (commit_c) begin
              state  <= ST_PROG;
              slot_q <= '0;
              busy   <= 1'b1;
            end else begin
              state <= ST_IDLE;
            end
          end else if (byte_valid) begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        ST_PROG: begin
          if (!scan_done) begin
            ram_we    <= rd_valid && !prot_hit;
            ram_addr  <= chk_addr;
            ram_wdata <= rd_data;
            slot_q    <= slot_q + 1'b1;
          end
          if (finish) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            clr_wel <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_prog_seq_chk.sv
module page_prog_seq_chk #(
  parameter int ADDR_W = 9,
  parameter int IDX_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_rise_full,
  input logic              wel,
  input logic              wp_n,
  input logic              prot_hit,
  input logic              busy,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic              clr_wel
);
  assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> busy);

  assert_clr_at_fall_R10: assert property (@(posedge clk) disable iff (rst)
    clr_wel |-> (!busy && $past(busy)));

  assert_clr_single_R10: assert property (@(posedge clk) disable iff (rst)
    clr_wel |=> !clr_wel);

  assert_skip_protected_R8: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> !$past(prot_hit));

  assert_commit_cause_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cs_rise_full && wel && wp_n));

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |->
      (ram_addr[ADDR_W-1:IDX_W] == $past(ram_addr[ADDR_W-1:IDX_W])));
endmodule

bind page_prog_seq page_prog_seq_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .cs_rise_full(cs_rise_full), .wel(wel), .wp_n(wp_n),
  .prot_hit(prot_hit), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
  .clr_wel(clr_wel)
);

// File: tb/page_prog_seq_bench.sv
module page_prog_seq_bench;
  localparam int CYC = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_start = 0, byte_valid = 0, cs_rise_full = 0, cs_rise_partial = 0;
  logic       wel = 0, wp_n = 1;
  logic [8:0] start_addr = '0;
  logic [7:0] byte_data = '0;
  logic [8:0] chk_addr, ram_addr;
  logic [7:0] ram_wdata;
  logic       prot_hit, busy, ram_we, clr_wel;
  logic       prot_en = 0;
  logic [8:0] prot_floor = '0;

  int vectors = 0, fails = 0;
  int rec_n = 0, busy_cyc = 0, clr_n = 0;
  logic [16:0] rec [0:63];

  always #4 clk = ~clk;

  assign prot_hit = prot_en && (chk_addr >= prot_floor);

  page_prog_seq #(.CYCLE_CLKS(CYC)) u_page_prog_seq (
    .clk(clk), .rst(rst), .wr_start(wr_start), .start_addr(start_addr),
    .byte_valid(byte_valid), .byte_data(byte_data), .cs_rise_full(cs_rise_full),
    .cs_rise_partial(cs_rise_partial), .wel(wel), .wp_n(wp_n), .chk_addr(chk_addr),
    .prot_hit(prot_hit), .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .clr_wel(clr_wel)
  );

  always @(negedge clk) begin
    if (!rst) begin
      if (ram_we && rec_n < 64) begin
        rec[rec_n] = {ram_addr, ram_wdata};
        rec_n++;
      end
      if (busy) busy_cyc++;
      if (clr_wel) clr_n++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  function automatic [7:0] dat(input [8:0] sa, input int n, input int i);
    return 8'(int'(sa) * 37 + n * 11 + i * 5 + 3);
  endfunction

  // endk: 0 full rise, 1 partial rise
  // wpm: 0 none, 1 low at rise, 2 glitch during bytes, 3 low during cycle
  task automatic txn(input [8:0] sa, input int n, input int endk, input bit welv,
                     input int wpm, input bit inject, input string tag);
    bit         ev [8];
    logic [7:0] ed [8];
    bit         commit;
    int         en;
    logic [16:0] ex [8];
    en = 0;
    for (int s = 0; s < 8; s++) begin ev[s] = 0; ed[s] = '0; end
    rec_n = 0; busy_cyc = 0; clr_n = 0;
    wel = welv; wp_n = 1;
    wr_start = 1; start_addr = sa; tick(); wr_start = 0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1; byte_data = dat(sa, n, i);
      if (wpm == 2 && i == 0) wp_n = 0;
      tick();
      byte_valid = 0; wp_n = 1;
      ev[(int'(sa[2:0]) + i) % 8] = 1;
      ed[(int'(sa[2:0]) + i) % 8] = dat(sa, n, i);
    end
    if (wpm == 1) wp_n = 0;
    if (endk == 0) cs_rise_full = 1; else cs_rise_partial = 1;
    tick();
    cs_rise_full = 0; cs_rise_partial = 0; wp_n = 1;
    if (wpm == 3) wp_n = 0;
    if (inject) begin
      wr_start = 1; start_addr = sa ^ 9'h1f0; tick(); wr_start = 0;
      byte_valid = 1; byte_data = 8'hEE; tick(); byte_valid = 0;
      cs_rise_full = 1; tick(); cs_rise_full = 0;
    end
    repeat (30) tick();
    wp_n = 1;
    repeat (3) tick();
    commit = (endk == 0) && welv && (wpm != 1) && (wpm != 2) && (n > 0);
    if (commit) begin
      for (int s = 0; s < 8; s++) begin
        if (ev[s] && !(prot_en && {sa[8:3], 3'(s)} >= prot_floor)) begin
          ex[en] = {sa[8:3], 3'(s), ed[s]};
          en++;
        end
      end
    end
    check(rec_n == en, {tag, " write count"}, rec_n, en);
    for (int k = 0; k < en && k < rec_n; k++)
      check(rec[k] == ex[k], {tag, " write addr/data"}, int'(rec[k]), int'(ex[k]));
    check(busy_cyc == (commit ? CYC : 0), {tag, " busy length R10"}, busy_cyc, commit ? CYC : 0);
    check(clr_n == (commit ? 1 : 0), {tag, " clr_wel pulses R10"}, clr_n, commit ? 1 : 0);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    check(busy == 0 && ram_we == 0 && clr_wel == 0, "R1 reset state",
          {busy, ram_we, clr_wel}, 0);
    // R2 R3 R9 sweep of offsets and byte counts
    for (int off = 0; off < 8; off++)
      for (int n = 1; n <= 10; n++)
        txn(9'(((off * 7 + n * 3) % 64) * 8 + off), n, 0, 1, 0, 0, "R2_R3_R9");
    txn(9'h0a5, 3, 1, 1, 0, 0, "R4 partial rise");
    txn(9'h133, 4, 0, 0, 0, 0, "R5 wel clear");
    txn(9'h044, 4, 0, 1, 1, 0, "R5 wp low at rise");
    txn(9'h07a, 5, 0, 1, 2, 0, "R6 wp glitch");
    txn(9'h0f1, 6, 0, 1, 3, 0, "R7 wp during cycle");
    prot_en = 1; prot_floor = 9'h1c3;
    txn(9'h1c0, 8, 0, 1, 0, 0, "R8 protected tail");
    txn(9'h1c6, 4, 0, 1, 0, 0, "R8 protected wrap");
    prot_en = 0;
    txn(9'h062, 3, 0, 1, 0, 1, "R11 ignored while busy");
    txn(9'h0c4, 0, 0, 1, 0, 0, "R12 no data");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule